// File: doc/BRIEF.md
# Flag-Gated Two-Stage Pipeline with Parking Buffer

The block passes samples through two processing stages, each with a one-bit busy flag. Every accepted sample first enters a pre-processing stage. The result then goes to the main stage when that stage is free. When the main stage is busy, the result goes into a small parking FIFO, where it waits until the main stage frees up. The arithmetic in each stage is a placeholder: the pre-stage adds a constant, and the main stage holds the sample for a fixed number of periods and then adds a second constant.

The block has one base clock. The long period, which paces the main stage and the parking buffer, is a strobe that fires on every second clock. The short period is every clock. When the main stage is free, the input side runs at the long period. While the main stage is busy, the input side runs at the short period, so it keeps filling the parking buffer instead of pushing back on the producer. A stall output is raised only when a sample cannot be taken without risking loss.

Top module: `flag_gated_pipe`

## Requirements
- R1: A synchronous active-high reset clears both flags, empties the parking buffer, drops any output and returns the input side to the long period. On the first clock after reset is released, `in_stall` is 1.
- R2: Every result equals the input plus `B_BIAS` plus `A_BIAS`, taken modulo 2^`W`. The defaults are 1 and 256.
- R3: `main_flag` rises when the main stage takes a sample and stays 1 for `LAT` long periods (2·`LAT` clocks). It falls on the same clock edge that raises `out_valid`. `out_valid` is a single-clock pulse.
- R4: When the main stage is free and the parking buffer is empty, the pre-stage result moves straight into the main stage on the next long-period strobe. The sample then appears 2·`LAT`+3 clocks after the clock at whose low phase it was offered and taken.
- R5: When the main stage frees up, parked samples are issued before any newer pre-stage result. Outputs leave in input order.
- R6: While `main_flag` is 0, an input is taken only on a long-period strobe. While `main_flag` is 1, an input may be taken on consecutive clocks.
- R7: The parking buffer holds `DEPTH` samples. When the pre-stage result can go nowhere, `in_stall` is 1, and no offered sample is ever lost.
- R8: The main stage takes a sample from the parking buffer only on a long-period strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Producer offers `in_data` |
| in_data | input | W | Sample in |
| in_stall | output | 1 | Sample not taken this clock; keep offering it |
| out_valid | output | 1 | One-clock pulse: `out_data` holds a result |
| out_data | output | W | Result out |
| pre_flag | output | 1 | Pre-stage busy (holds an unforwarded result) |
| main_flag | output | 1 | Main stage busy |

## Verification
Several behaviours are checked by assertions on every cycle:
- the main stage loads only while its flag is 0;
- the parking buffer never overflows or underflows;
- the buffer and the pre-stage never feed the main stage in the same cycle, and a direct hand-over happens only with the buffer empty;
- parked issue and idle-time input acceptance happen only on long-period strobes;
- `main_flag` falls exactly when a result is presented.

The bench scenarios cover what no single-cycle property can show:
- the result values;
- end-to-end latency;
- the two input rates seen as accept-to-accept gaps;
- stalls that appear only while the buffer is full;
- preservation of order across a burst;
- the loss of all in-flight work on a reset part-way through a burst.

// File: rtl/fgp_pkg.sv
package fgp_pkg;
  typedef enum logic {SRC_PRE = 1'b0, SRC_PARK = 1'b1} src_sel_e;
  typedef enum logic {RATE_LONG = 1'b0, RATE_SHORT = 1'b1} rate_e;
endpackage

// File: rtl/fgp_ctrl.sv
module fgp_ctrl
  import fgp_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     in_valid,
  input  logic     b_valid,
  input  logic     a_busy,
  input  logic     park_empty,
  input  logic     park_full,
  output logic     slow_en,
  output logic     b_take,
  output logic     b_to_a,
  output logic     push,
  output logic     pop,
  output logic     a_load,
  output src_sel_e a_sel,
  output logic     stall
);
  logic  phase;
  rate_e rate;
  logic  up_en, b_go;

  always_ff @(posedge clk) begin
    if (rst) phase <= 1'b0;
    else     phase <= ~phase;
  end

  assign slow_en = phase;
  assign rate    = a_busy ? RATE_SHORT : RATE_LONG;
  assign up_en   = (rate == RATE_SHORT) | slow_en;

  assign pop     = slow_en & ~a_busy & ~park_empty;
  assign b_to_a  = slow_en & ~a_busy & park_empty & b_valid;
  assign push    = up_en & b_valid & ~b_to_a & (~park_full | pop);
  assign b_go    = b_to_a | push;
  assign stall   = ~up_en | (b_valid & ~b_go);
  assign b_take  = in_valid & ~stall;
  assign a_load  = b_to_a | pop;
  assign a_sel   = pop ? SRC_PARK : SRC_PRE;
endmodule

// File: rtl/fgp_pre_stage.sv
module fgp_pre_stage #(
  parameter int W      = 16,
  parameter int B_BIAS = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         take,
  input  logic         leave,
  input  logic [W-1:0] din,
  output logic         busy,
  output logic [W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      dout <= '0;
    end else if (take) begin
      busy <= 1'b1;
      dout <= din + W'(B_BIAS);
    end else if (leave) begin
      busy <= 1'b0;
    end
  end

  a_r7_no_overwrite: assert property (@(posedge clk) disable iff (rst)
    (take && busy) |-> leave);
endmodule

// File: rtl/fgp_park_fifo.sv
module fgp_park_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr, wnext, rnext;
  logic [CW-1:0] count;

  generate
    if ((1 << AW) == DEPTH) begin : g_pow2
      assign wnext = wptr + 1'b1;
      assign rnext = rptr + 1'b1;
    end else begin : g_wrap
      assign wnext = (wptr == LAST) ? '0 : wptr + 1'b1;
      assign rnext = (rptr == LAST) ? '0 : rptr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= wnext;
      if (pop)  rptr <= rnext;
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  assign head  = mem[rptr];
  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (push && full) |-> pop);
  a_r7_no_underflow: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
endmodule

// File: rtl/fgp_main_stage.sv
module fgp_main_stage #(
  parameter int W      = 16,
  parameter int LAT    = 3,
  parameter int A_BIAS = 256
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         slow_en,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic         busy,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  localparam int CNW = $clog2(LAT + 1);

  logic [CNW-1:0] cnt;
  logic [W-1:0]   hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      cnt       <= '0;
      hold      <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      if (slow_en) begin
        if (load) begin
          busy <= 1'b1;
          cnt  <= CNW'(LAT);
          hold <= din;
        end else if (busy) begin
          if (cnt == CNW'(1)) begin
            busy      <= 1'b0;
            out_valid <= 1'b1;
            out_data  <= hold + W'(A_BIAS);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      end
    end
  end

  a_r3_load_when_free: assert property (@(posedge clk) disable iff (rst)
    load |-> !busy);
  a_r3_flag_falls_on_output: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (!busy && $past(busy)));
endmodule

// File: rtl/flag_gated_pipe.sv
module flag_gated_pipe
  import fgp_pkg::*;
#(
  parameter int W      = 16,
  parameter int DEPTH  = 4,
  parameter int LAT    = 3,
  parameter int B_BIAS = 1,
  parameter int A_BIAS = 256
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         in_stall,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         pre_flag,
  output logic         main_flag
);
  logic         slow_en, b_take, b_to_a, push, pop, a_load;
  logic         park_empty, park_full;
  src_sel_e     a_sel;
  logic [W-1:0] b_data, park_head, a_din;

  fgp_ctrl u_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .b_valid(pre_flag),
    .a_busy(main_flag), .park_empty(park_empty), .park_full(park_full),
    .slow_en(slow_en), .b_take(b_take), .b_to_a(b_to_a), .push(push),
    .pop(pop), .a_load(a_load), .a_sel(a_sel), .stall(in_stall)
  );

  fgp_pre_stage #(.W(W), .B_BIAS(B_BIAS)) u_pre (
    .clk(clk), .rst(rst), .take(b_take), .leave(b_to_a | push),
    .din(in_data), .busy(pre_flag), .dout(b_data)
  );

  fgp_park_fifo #(.W(W), .DEPTH(DEPTH)) u_park (
    .clk(clk), .rst(rst), .push(push), .din(b_data), .pop(pop),
    .head(park_head), .empty(park_empty), .full(park_full)
  );

  assign a_din = (a_sel == SRC_PARK) ? park_head : b_data;

  fgp_main_stage #(.W(W), .LAT(LAT), .A_BIAS(A_BIAS)) u_main (
    .clk(clk), .rst(rst), .slow_en(slow_en), .load(a_load), .din(a_din),
    .busy(main_flag), .out_valid(out_valid), .out_data(out_data)
  );

  a_r4_direct_only_when_empty: assert property (@(posedge clk) disable iff (rst)
    b_to_a |-> park_empty);
  a_r5_parked_first: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pop, b_to_a}));
  a_r6_idle_pace: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_stall && !main_flag) |-> slow_en);
  a_r8_issue_on_strobe: assert property (@(posedge clk) disable iff (rst)
    pop |-> slow_en);
endmodule

// File: tb/flag_gated_pipe_test.sv
module flag_gated_pipe_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16, DEPTH = 4, LAT = 3, BB = 1, AB = 256;

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic in_stall, out_valid, pre_flag, main_flag;
  logic [W-1:0] out_data;

  int n_pass = 0, n_fail = 0, cyc = 0, n_got = 0;
  logic [W-1:0] got [64];
  int  got_cyc [64];
  bit  got_flag [64];

  flag_gated_pipe #(.W(W), .DEPTH(DEPTH), .LAT(LAT), .B_BIAS(BB), .A_BIAS(AB)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_stall(in_stall), .out_valid(out_valid), .out_data(out_data),
    .pre_flag(pre_flag), .main_flag(main_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst && out_valid && n_got < 64) begin
      got[n_got]      = out_data;
      got_cyc[n_got]  = cyc;
      got_flag[n_got] = main_flag;
      n_got++;
    end
  end

  function automatic logic [W-1:0] expect_of(input logic [W-1:0] d);
    return d + W'(BB) + W'(AB);
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    if (ok) n_pass++;
    else begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_pass, n_pass + n_fail);
  endtask

  task automatic send(input logic [W-1:0] d, output int acc, output bit waited_busy);
    waited_busy = 0;
    acc = -1;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    for (int i = 0; i < 1000; i++) begin
      #1;
      if (!in_stall) begin
        acc = cyc;
        @(posedge clk);
        #1 in_valid = 1'b0;
        break;
      end
      if (main_flag) waited_busy = 1;
      @(negedge clk);
    end
  endtask

  task automatic wait_out(input int n);
    for (int i = 0; i < 600 && n_got < n; i++) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (!main_flag && !pre_flag) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    n_got = 0;
  endtask

  // R1: state right after reset
  task automatic t_reset();
    do_reset();
    #1;
    chk(main_flag == 0, "R1", "main_flag after reset", main_flag, 0);
    chk(pre_flag == 0, "R1", "pre_flag after reset", pre_flag, 0);
    chk(out_valid == 0, "R1", "out_valid after reset", out_valid, 0);
    chk(in_stall == 1, "R1", "in_stall first clock", in_stall, 1);
  endtask

  // R2 R3 R4: single sample through the direct path
  task automatic t_single();
    int acc, busy_clks;
    bit wb;
    busy_clks = 0;
    n_got = 0;
    send(16'h1234, acc, wb);
    for (int i = 0; i < 100 && n_got < 1; i++) begin
      @(negedge clk);
      if (main_flag) busy_clks++;
    end
    chk(n_got == 1, "R2", "single output count", n_got, 1);
    chk(got[0] == expect_of(16'h1234), "R2", "single value", got[0], expect_of(16'h1234));
    chk(got_flag[0] == 0, "R3", "flag at output", got_flag[0], 0);
    chk(busy_clks == 2*LAT, "R3", "busy clocks", busy_clks, 2*LAT);
    chk(got_cyc[0] - acc == 2*LAT + 3, "R4", "direct latency", got_cyc[0] - acc, 2*LAT + 3);
    @(negedge clk);
    chk(out_valid == 0, "R3", "pulse width", out_valid, 0);
    wait_idle();
  endtask

  // R6 R5: input pace when idle vs busy, order kept
  task automatic t_pace();
    int a0, a1, a2;
    bit wb;
    logic [W-1:0] v [3] = '{16'h0010, 16'h0020, 16'hFFFF};
    n_got = 0;
    send(v[0], a0, wb);
    send(v[1], a1, wb);
    send(v[2], a2, wb);
    chk(a1 - a0 == 2, "R6", "idle accept gap", a1 - a0, 2);
    chk(a2 - a1 == 1, "R6", "busy accept gap", a2 - a1, 1);
    wait_out(3);
    chk(n_got == 3, "R5", "pace output count", n_got, 3);
    for (int i = 0; i < 3; i++)
      chk(got[i] == expect_of(v[i]), "R5", "pace order/value", got[i], expect_of(v[i]));
    wait_idle();
  endtask

  // R7 R5 R8: burst larger than the parking buffer
  task automatic t_burst();
    int acc;
    bit wb, any_full;
    any_full = 0;
    n_got = 0;
    for (int i = 0; i < 10; i++) begin
      send(W'(i * 16'h0111 + 7), acc, wb);
      if (wb) any_full = 1;
    end
    chk(any_full, "R7", "stall while buffer full", any_full, 1);
    wait_out(10);
    chk(n_got == 10, "R7", "no sample lost", n_got, 10);
    for (int i = 0; i < 10; i++)
      chk(got[i] == expect_of(W'(i * 16'h0111 + 7)), "R5", "burst order",
          got[i], expect_of(W'(i * 16'h0111 + 7)));
    for (int i = 1; i < 10; i++)
      chk(got_cyc[i] - got_cyc[i-1] == 2*LAT + 2, "R8", "parked issue spacing",
          got_cyc[i] - got_cyc[i-1], 2*LAT + 2);
    wait_idle();
  endtask

  // R1: reset part-way through a burst discards in-flight work
  task automatic t_mid_reset();
    int acc;
    bit wb;
    for (int i = 0; i < 6; i++) send(W'(16'h0A00 + i), acc, wb);
    do_reset();
    #1;
    chk(main_flag == 0 && pre_flag == 0, "R1", "flags after mid reset",
        {main_flag, pre_flag}, 0);
    send(16'h0777, acc, wb);
    wait_out(1);
    repeat (40) @(negedge clk);
    chk(n_got == 1, "R1", "no stale outputs", n_got, 1);
    chk(got[0] == expect_of(16'h0777), "R1", "post-reset value", got[0], expect_of(16'h0777));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    chk(0, "WD", "watchdog expired", 0, 1);
    report();
    $finish;
  end

  initial begin
    t_reset();
    t_single();
    t_pace();
    t_burst();
    t_mid_reset();
    report();
    $finish;
  end
endmodule